// File: doc/BRIEF.md
# Serial TDM Time-Slot Switch with Per-Slot Latency Choice

This block moves bytes between time slots of serial TDM streams. It has a set of serial input streams and a set of serial output streams, each carrying a fixed number of 8-bit slots per 125 µs frame, one bit per clock, most significant bit first. Input bytes are deserialised and stored in a two-bank data store, addressed by bank, stream and slot. The banks swap roles at every frame boundary. Each output slot owns one connection entry. The entry names a source stream and slot, an enable bit, and a mode bit. The mode bit picks one of two policies. The first keeps every byte of an output frame from one common input frame, which wideband multi-slot channels need. The second takes the byte from the frame still arriving whenever the source slot has arrived early enough, which cuts delay for voice.

A processor writes the entries through a small write/read port. The port writes a shadow copy of the table, and the shadow is committed to the live table only at a frame boundary. A frame is therefore never switched with a mixture of old and new settings. A disabled output slot sends all ones, and its per-stream drive enable stays low for the whole slot.

Top module: `tsi_switch`

## Requirements
- R1: After reset every `tx` bit is 1, every `tx_oe` bit is 0, and every connection entry reads back as 0 (disabled).
- R2: A high `fsync` places the current clock at frame position 0, which is bit 7 of slot 0. Position p carries bit 7-(p mod 8) of slot p/8, and input bits are sampled in the clock where they are presented. The output bit for frame position p appears on `tx` one clock later, also MSB first.
- R3: An output slot whose entry has the enable bit (bit 8) at 0 sends 0xFF, with `tx_oe` low for all 8 bits of that slot.
- R4: With the enable bit set and mode bit 7 at 0 (whole-frame mode), output slot k of frame F carries the byte that arrived in frame F-1 on the source stream (bits 6:5) and source slot (bits 4:0).
- R5: With mode bit 7 at 1 (low-delay mode) and source slot j ≤ k-2, output slot k of frame F carries the byte from source slot j of frame F.
- R6: In low-delay mode with source slot j > k-2, the byte comes from frame F-1, as in R4.
- R7: An entry written in any clock of frame F, including the clock at position 0 and the clock at position 255, governs output slots from frame F+1 onward. Frame F still uses the entry that was live at its start.
- R8: Writing `cfg_wdata` with `cfg_we` high stores the entry at `cfg_addr` = {output stream, output slot}. In the next clock `cfg_rdata` shows the entry at `cfg_addr`.
- R9: For an enabled output slot, `tx_oe` of that stream is high for all 8 bits of the slot and changes only where a slot begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame marker, high at slot 0 bit 7 |
| rx | input | STREAMS | Serial input bit per stream |
| tx | output | STREAMS | Serial output bit per stream |
| tx_oe | output | STREAMS | Per-stream drive enable for the current output slot |
| cfg_we | input | 1 | Connection entry write strobe |
| cfg_addr | input | log2(STREAMS)+log2(SLOTS) | Output stream (high bits) and output slot (low bits) |
| cfg_wdata | input | 2+log2(STREAMS)+log2(SLOTS) | Entry: enable, mode, source stream, source slot |
| cfg_rdata | output | 2+log2(STREAMS)+log2(SLOTS) | Shadow entry at `cfg_addr` |

## Verification
The bench builds the block with its defaults: four streams, 32 slots of eight bits, and a two-slot lead for low-delay reads. These values give a full 256-position frame, so the run reaches the wrap from slot 31 back to slot 0 and the exact j = k-2 edge between current-frame and previous-frame reads. They also reach entry writes placed on the first and the last position of a frame. Every output byte of eight consecutive frames is predicted from the generated input pattern and the model connection table, and compared against the output.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int TSI_STREAMS = 4;
    localparam int TSI_SLOTS   = 32;
    localparam int TSI_BYTE_W  = 8;
    localparam int TSI_LEAD    = 2;

    typedef enum logic {
        SW_WHOLE_FRAME = 1'b0,
        SW_LOW_DELAY   = 1'b1
    } sw_mode_e;
endpackage

// File: rtl/tsi_timer.sv
module tsi_timer #(
    parameter int SLOTS  = 32,
    parameter int BYTE_W = 8,
    localparam int PW = $clog2(SLOTS) + $clog2(BYTE_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    output logic [PW-1:0] pos,
    output logic          cur_bank
);
    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          bank;
    } tmr_t;

    tmr_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = fsync ? '0 : st_q.cnt + 1'b1;
        st_d.bank = (st_d.cnt == '0) ? ~st_q.bank : st_q.bank;
        pos       = st_d.cnt;
        cur_bank  = st_d.bank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '1;
            st_q.bank <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tsi_conn.sv
module tsi_conn #(
    parameter int STREAMS = 4,
    parameter int SLOTS   = 32,
    localparam int SW = $clog2(STREAMS),
    localparam int TW = $clog2(SLOTS),
    localparam int AW = SW + TW,
    localparam int EW = 2 + SW + TW,
    localparam int NCONN = STREAMS * SLOTS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_start,
    input  logic [TW-1:0]              rd_slot,
    input  logic                       we,
    input  logic [AW-1:0]              addr,
    input  logic [EW-1:0]              wdata,
    output logic [EW-1:0]              rdata,
    output logic [STREAMS-1:0][EW-1:0] entry
);
    typedef struct packed {
        logic [NCONN-1:0][EW-1:0] shadow;
        logic [NCONN-1:0][EW-1:0] live;
    } tbl_t;

    tbl_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (frame_start) st_d.live = st_q.shadow;
        if (we) st_d.shadow[addr] = wdata;
        rdata = st_q.shadow[addr];
    end

    for (genvar o = 0; o < STREAMS; o++) begin : g_rd
        logic [AW-1:0] idx;
        assign idx      = {SW'(o), rd_slot};
        assign entry[o] = frame_start ? st_q.shadow[idx] : st_q.live[idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tsi_store.sv
module tsi_store #(
    parameter int STREAMS = 4,
    parameter int SLOTS   = 32,
    parameter int BYTE_W  = 8,
    localparam int SW = $clog2(STREAMS),
    localparam int TW = $clog2(SLOTS),
    localparam int BW = $clog2(BYTE_W),
    localparam int PW = TW + BW,
    localparam int RW = 1 + SW + TW
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [PW-1:0]                  pos,
    input  logic                           cur_bank,
    input  logic [STREAMS-1:0]             rx,
    input  logic [STREAMS-1:0][RW-1:0]     rd_sel,
    output logic [STREAMS-1:0][BYTE_W-1:0] rd_byte
);
    typedef struct packed {
        logic [STREAMS-1:0][BYTE_W-1:0]                 shf;
        logic [1:0][STREAMS-1:0][SLOTS-1:0][BYTE_W-1:0] mem;
    } store_t;

    store_t st_q, st_d;

    logic [BW-1:0] bit_idx;
    logic [TW-1:0] slot_idx;
    assign bit_idx  = pos[BW-1:0];
    assign slot_idx = pos[PW-1:BW];

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < STREAMS; s++) begin
            st_d.shf[s] = {st_q.shf[s][BYTE_W-2:0], rx[s]};
            if (bit_idx == BW'(BYTE_W - 1))
                st_d.mem[cur_bank][s][slot_idx] = st_d.shf[s];
        end
        for (int o = 0; o < STREAMS; o++)
            rd_byte[o] = st_q.mem[rd_sel[o][RW-1]][rd_sel[o][SW+TW-1:TW]][rd_sel[o][TW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
    import tsi_pkg::*;
#(
    parameter int STREAMS = 4,
    parameter int SLOTS   = 32,
    parameter int BYTE_W  = 8,
    parameter int LEAD    = 2,
    localparam int SW = $clog2(STREAMS),
    localparam int TW = $clog2(SLOTS),
    localparam int BW = $clog2(BYTE_W),
    localparam int PW = TW + BW,
    localparam int EW = 2 + SW + TW,
    localparam int RW = 1 + SW + TW
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [PW-1:0]                  pos,
    input  logic                           cur_bank,
    input  logic [STREAMS-1:0][EW-1:0]     entry,
    input  logic [STREAMS-1:0][BYTE_W-1:0] rd_byte,
    output logic [STREAMS-1:0][RW-1:0]     rd_sel,
    output logic [STREAMS-1:0]             tx,
    output logic [STREAMS-1:0]             tx_oe
);
    typedef struct packed {
        logic [STREAMS-1:0][BYTE_W-1:0] shf;
        logic [STREAMS-1:0]             bit_o;
        logic [STREAMS-1:0]             oe;
    } ser_t;

    ser_t st_q, st_d;

    logic [TW:0] slot_ext;
    assign slot_ext = {1'b0, pos[PW-1:BW]};

    always_comb begin
        st_d = st_q;
        for (int o = 0; o < STREAMS; o++) begin
            logic          en;
            logic          bank_sel;
            logic [TW-1:0] src_slot;
            logic [SW-1:0] src_strm;
            logic [BYTE_W-1:0] byte_v;
            en       = entry[o][EW-1];
            src_strm = entry[o][SW+TW-1:TW];
            src_slot = entry[o][TW-1:0];
            bank_sel = ~cur_bank;
            if (sw_mode_e'(entry[o][EW-2]) == SW_LOW_DELAY &&
                ({1'b0, src_slot} + (TW+1)'(LEAD)) <= slot_ext)
                bank_sel = cur_bank;
            rd_sel[o] = {bank_sel, src_strm, src_slot};
            byte_v    = en ? rd_byte[o] : '1;
            if (pos[BW-1:0] == '0) begin
                st_d.bit_o[o] = byte_v[BYTE_W-1];
                st_d.shf[o]   = {byte_v[BYTE_W-2:0], 1'b1};
                st_d.oe[o]    = en;
            end else begin
                st_d.bit_o[o] = st_q.shf[o][BYTE_W-1];
                st_d.shf[o]   = {st_q.shf[o][BYTE_W-2:0], 1'b1};
            end
        end
    end

    assign tx    = st_q.bit_o;
    assign tx_oe = st_q.oe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shf   <= '1;
            st_q.bit_o <= '1;
            st_q.oe    <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int STREAMS = TSI_STREAMS,
    parameter int SLOTS   = TSI_SLOTS,
    parameter int BYTE_W  = TSI_BYTE_W,
    parameter int LEAD    = TSI_LEAD,
    localparam int SW = $clog2(STREAMS),
    localparam int TW = $clog2(SLOTS),
    localparam int BW = $clog2(BYTE_W),
    localparam int PW = TW + BW,
    localparam int AW = SW + TW,
    localparam int EW = 2 + SW + TW,
    localparam int RW = 1 + SW + TW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fsync,
    input  logic [STREAMS-1:0] rx,
    output logic [STREAMS-1:0] tx,
    output logic [STREAMS-1:0] tx_oe,
    input  logic               cfg_we,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [EW-1:0]      cfg_wdata,
    output logic [EW-1:0]      cfg_rdata
);
    logic [PW-1:0]                  pos;
    logic                           cur_bank;
    logic [STREAMS-1:0][EW-1:0]     entry;
    logic [STREAMS-1:0][RW-1:0]     rd_sel;
    logic [STREAMS-1:0][BYTE_W-1:0] rd_byte;

    tsi_timer #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .fsync(fsync),
        .pos(pos), .cur_bank(cur_bank)
    );

    tsi_conn #(.STREAMS(STREAMS), .SLOTS(SLOTS)) u_conn (
        .clk(clk), .rst_n(rst_n), .frame_start(pos == '0),
        .rd_slot(pos[PW-1:BW]), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .entry(entry)
    );

    tsi_store #(.STREAMS(STREAMS), .SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .pos(pos), .cur_bank(cur_bank),
        .rx(rx), .rd_sel(rd_sel), .rd_byte(rd_byte)
    );

    tsi_tx #(.STREAMS(STREAMS), .SLOTS(SLOTS), .BYTE_W(BYTE_W), .LEAD(LEAD)) u_tx (
        .clk(clk), .rst_n(rst_n), .pos(pos), .cur_bank(cur_bank),
        .entry(entry), .rd_byte(rd_byte), .rd_sel(rd_sel),
        .tx(tx), .tx_oe(tx_oe)
    );
endmodule

// File: rtl/tsi_sva.sv
module tsi_sva #(
    parameter int STREAMS = 4,
    parameter int AW = 7,
    parameter int EW = 9,
    parameter int PW = 8,
    parameter int BW = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [STREAMS-1:0] tx,
    input logic [STREAMS-1:0] tx_oe,
    input logic               cfg_we,
    input logic [AW-1:0]      cfg_addr,
    input logic [EW-1:0]      cfg_wdata,
    input logic [EW-1:0]      cfg_rdata,
    input logic [PW-1:0]      pos,
    input logic               cur_bank
);
    AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        &(tx | tx_oe)); // R3

    AST_OE_AT_SLOT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pos[BW-1:0] != BW'(1)) |-> $stable(tx_oe)); // R9

    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && cfg_addr == $past(cfg_addr)) |-> cfg_rdata == $past(cfg_wdata)); // R8

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != '0) |-> $stable(cur_bank)); // R2
endmodule

bind tsi_switch tsi_sva #(
    .STREAMS(STREAMS), .AW(AW), .EW(EW), .PW(PW), .BW(BW)
) u_sva (
    .clk(clk), .rst_n(rst_n), .tx(tx), .tx_oe(tx_oe),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pos(pos), .cur_bank(cur_bank)
);

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int NT = 32;
    localparam int NFR = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fsync = 1'b0;
    logic [NS-1:0] rx = '0;
    logic [NS-1:0] tx, tx_oe;
    logic          cfg_we = 1'b0;
    logic [6:0]    cfg_addr = '0;
    logic [8:0]    cfg_wdata = '0;
    logic [8:0]    cfg_rdata;

    int total = 0;
    int bad = 0;
    bit go = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        int          fr;
        int          st;
        int          sl;
        logic [7:0]  data;
        logic        oe;
        string       tag;
    } item_t;

    item_t sb[$];
    logic [8:0] shadow_m [NS*NT];
    logic [8:0] live_m   [NS*NT];
    logic [8:0] prev_m   [NS*NT];

    tsi_switch u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .rx(rx),
        .tx(tx), .tx_oe(tx_oe), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [7:0] in_byte(int f, int s, int j);
        if (f < 0) return 8'h00;
        return 8'(f * 37 + s * 71 + j * 13 + 5);
    endfunction

    function automatic logic [8:0] mk(bit en, bit low, int s, int j);
        return {en, low, 2'(s), 5'(j)};
    endfunction

    // Entry writes: {frame, position} -> {output stream, output slot}
    task automatic script(input int f, input int p, output bit w,
                          output logic [6:0] a, output logic [8:0] d);
        w = 1'b1;
        case ({f, p})
            {32'd0, 32'd20}:  begin a = {2'd0, 5'd10}; d = mk(1, 0, 2, 3);  end // R4
            {32'd0, 32'd21}:  begin a = {2'd1, 5'd10}; d = mk(1, 0, 2, 4);  end // R4
            {32'd0, 32'd22}:  begin a = {2'd2, 5'd9};  d = mk(1, 1, 3, 7);  end // R5
            {32'd0, 32'd23}:  begin a = {2'd3, 5'd9};  d = mk(1, 1, 0, 8);  end // R6
            {32'd0, 32'd24}:  begin a = {2'd0, 5'd31}; d = mk(1, 1, 1, 29); end // R5 edge
            {32'd0, 32'd25}:  begin a = {2'd1, 5'd0};  d = mk(1, 1, 2, 31); end // R6
            {32'd0, 32'd26}:  begin a = {2'd3, 5'd5};  d = mk(1, 0, 3, 31); end // R4
            {32'd0, 32'd27}:  begin a = {2'd2, 5'd20}; d = mk(1, 1, 0, 20); end // R6
            {32'd2, 32'd0}:   begin a = {2'd0, 5'd10}; d = mk(1, 1, 2, 3);  end // R7
            {32'd2, 32'd200}: begin a = {2'd0, 5'd2};  d = mk(1, 0, 1, 1);  end // R7
            {32'd3, 32'd40}:  begin a = {2'd2, 5'd9};  d = mk(0, 1, 3, 7);  end // R3
            {32'd4, 32'd255}: begin a = {2'd1, 5'd10}; d = mk(1, 1, 1, 0);  end // R7
            {32'd5, 32'd128}: begin a = {2'd3, 5'd31}; d = mk(1, 1, 3, 0);  end // R5
            default: begin w = 1'b0; a = '0; d = '0; end
        endcase
    endtask

    task automatic push_frame(input int f);
        for (int i = 0; i < NS*NT; i++) begin
            prev_m[i] = live_m[i];
            live_m[i] = shadow_m[i];
        end
        for (int k = 0; k < NT; k++) begin
            for (int o = 0; o < NS; o++) begin
                item_t it;
                logic [8:0] e;
                int j, s;
                e = live_m[o*NT + k];
                j = int'(e[4:0]);
                s = int'(e[6:5]);
                it.fr = f; it.st = o; it.sl = k;
                it.oe = e[8];
                if (!e[8]) it.data = 8'hFF;
                else if (e[7] && j + 2 <= k) it.data = in_byte(f, s, j);
                else it.data = in_byte(f - 1, s, j);
                if (f > 0 && e != prev_m[o*NT + k]) it.tag = "R7";
                else if (!e[8]) it.tag = "R3";
                else if (!e[7]) it.tag = "R4";
                else if (j + 2 <= k) it.tag = "R5";
                else it.tag = "R6";
                sb.push_back(it);
            end
        end
    endtask

    // Driver
    initial begin
        for (int i = 0; i < NS*NT; i++) begin
            shadow_m[i] = '0; live_m[i] = '0; prev_m[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // reset state, still before the first active edge after release
        chk(tx == 4'hF, "R1 tx after reset", int'(tx), 'hF);
        chk(tx_oe == 4'h0, "R1 tx_oe after reset", int'(tx_oe), 0);
        chk(cfg_rdata == 9'h0, "R1 entry readback after reset", int'(cfg_rdata), 0);
        for (int f = 0; f < NFR; f++) begin
            for (int p = 0; p < NT*8; p++) begin
                bit w;
                logic [6:0] a;
                logic [8:0] d;
                if (f != 0 || p != 0) @(negedge clk);
                if (cfg_we) begin
                    chk(cfg_rdata == cfg_wdata, "R8 readback", int'(cfg_rdata), int'(cfg_wdata));
                end
                if (p == 0) push_frame(f);
                if (f == 0 && p == 0) go = 1'b1;
                script(f, p, w, a, d);
                cfg_we = w;
                if (w) begin
                    cfg_addr = a;
                    cfg_wdata = d;
                    shadow_m[int'(a)] = d;
                end
                fsync = (p == 0);
                for (int s = 0; s < NS; s++)
                    rx[s] = in_byte(f, s, p / 8)[7 - (p % 8)];
            end
        end
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        finish_run();
    end

    // Monitor
    initial begin
        logic [7:0] acc [NS];
        logic [7:0] oes [NS];
        int mp;
        mp = 0;
        wait (go);
        forever begin
            @(negedge clk);
            for (int o = 0; o < NS; o++) begin
                acc[o] = {acc[o][6:0], tx[o]};
                oes[o] = {oes[o][6:0], tx_oe[o]};
            end
            if (mp % 8 == 7) begin
                for (int o = 0; o < NS; o++) begin
                    item_t it;
                    if (sb.size() == 0) begin
                        chk(1'b0, "R2 scoreboard underrun", 0, 1);
                    end else begin
                        it = sb.pop_front();
                        chk(it.st == o && it.sl == mp / 8, "R2 slot order",
                            it.sl, mp / 8);
                        chk(acc[o] == it.data, $sformatf("%s R2 data f%0d s%0d k%0d",
                            it.tag, it.fr, o, it.sl), int'(acc[o]), int'(it.data));
                        chk(oes[o] == {8{it.oe}}, $sformatf("%s R9 oe f%0d s%0d k%0d",
                            it.oe ? "R9" : "R3", it.fr, o, it.sl),
                            int'(oes[o]), int'({8{it.oe}}));
                    end
                end
            end
            mp = (mp + 1) % (NT*8);
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog R2", 0, 1);
        finish_run();
    end
endmodule